// File: doc/BRIEF.md
# Stereo Audio Serial Receiver

This block takes a two-channel audio serial stream from an external transmitter, which drives the bit clock, the left/right frame clock and the data line. All three are sampled in the local system clock domain, so the system clock must run well above the bit clock. The receiver turns each frame into a 24-bit left sample and a 24-bit right sample, and marks each new pair with a single-cycle valid strobe.

Run-time configuration inputs choose one of three justification formats and one of three word widths, and they can invert either serial clock. One capture path serves every combination. Each received bit lands at its final position in a 24-bit word, so narrower samples come out left-aligned with zeros below them. The receiver never drives the serial clocks. Configuration is meant to change only while the block is in reset.

Top module: `audio_serial_rx`

## Requirements
- R1: While rst_ni is low, and directly after it is released, left_o and right_o read zero and valid_o is low.
- R2: With fmt_i = 0 (I2S style, the reset default code), the sample MSB is taken at the second bit-clock sampling edge of a half-frame. Index 0 is the first sampling edge at which the new frame clock level is seen.
- R3: With fmt_i = 1 (left-justified), the sample MSB is taken at index 0 of the half-frame.
- R4: With fmt_i = 2 (right-justified), each half-frame is 32 bit clocks long and the LSB is taken at index 31. Only the last N bits (indices 32-N to 31) are kept.
- R5: wlen_i selects N: 0 gives 24 bits, 1 gives 20 bits, 2 gives 16 bits. The N-bit sample sits in bits 23 down to 24-N of the output, and every lower bit is zero.
- R6: Data bits at indices outside the N-bit capture window have no effect on the outputs.
- R7: When sck_inv_i is 1, bits are sampled on the falling edge of sck_i instead of the rising edge. When ws_inv_i is 1, frame clock high selects the left channel instead of the right.
- R8: A frame is a left half (logical frame clock 0) followed by a right half (logical frame clock 1). valid_o pulses for exactly one cycle per complete frame. After reset, no pulse is produced until a left half and then a right half have both been received, each beginning at a frame clock transition.
- R9: valid_o rises exactly 3 system clock cycles after the input edge of the bit clock that carries the first sampling edge of the next left half. left_o and right_o change only in that cycle and hold their values otherwise.
- R10: The unused codes fmt_i = 3 and wlen_i = 3 behave as I2S style and 24 bits respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Left/right frame clock, asynchronous |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Justification format code |
| wlen_i | input | 2 | Word width code |
| sck_inv_i | input | 1 | Sample on the falling bit clock edge |
| ws_inv_i | input | 1 | Invert frame clock channel sense |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe: new sample pair |

## Verification
An input edge on sck_i passes through two synchronizer flops and then the edge detector, which stores each bit during the following cycle. A finished frame therefore shows up on valid_o on the third system clock edge after the bit clock edge that begins the next left half. The bench changes its inputs on falling clock edges and records the cycle of every bit clock edge it drives. For each observed strobe it requires a distance of exactly 3 cycles, and it compares the data while the strobe is high. After the last frame, the bench waits out the full pipeline before it counts the strobes and checks that the outputs hold their values.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned WORD_W    = 24;
  localparam int unsigned HALF_BITS = 32;
  localparam int unsigned CNT_W     = $clog2(HALF_BITS) + 1;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    WL_24   = 2'd0,
    WL_20   = 2'd1,
    WL_16   = 2'd2,
    WL_RSVD = 2'd3
  } wlen_e;

  function automatic int word_bits(logic [1:0] code);
    case (code)
      WL_20:   return 20;
      WL_16:   return 16;
      default: return 24;
    endcase
  endfunction

  // index of the MSB inside a half-frame
  function automatic int first_idx(logic [1:0] fmt, int nbits);
    case (fmt)
      FMT_LJ:  return 0;
      FMT_RJ:  return int'(HALF_BITS) - nbits;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= async_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift
  import aud_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  output logic              done_o,
  output logic              done_right_o,
  output logic [WORD_W-1:0] done_word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              ws_q, seen_q, framed_q;
  logic [CNT_W-1:0]  k_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic              lr_chg;
  int                idx, nbits, first, bit_pos;

  assign lr_chg = samp_i && seen_q && (ws_i != ws_q);

  always_comb begin
    nbits   = word_bits(wlen_i);
    first   = first_idx(fmt_i, nbits);
    idx     = lr_chg ? 0 : int'(k_q);
    word_d  = lr_chg ? '0 : word_q;
    bit_pos = int'(WORD_W) - 1 - (idx - first);
    if (idx >= first && idx < first + nbits)
      word_d[5'(bit_pos)] = sd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q     <= 1'b0;
      seen_q   <= 1'b0;
      framed_q <= 1'b0;
      k_q      <= CNT_MAX;
      word_q   <= '0;
    end else if (samp_i) begin
      ws_q   <= ws_i;
      seen_q <= 1'b1;
      word_q <= word_d;
      if (lr_chg) begin
        framed_q <= 1'b1;
        k_q      <= CNT_W'(1);
      end else if (k_q != CNT_MAX) begin
        k_q <= k_q + CNT_W'(1);
      end
    end
  end

  assign done_o       = lr_chg && framed_q;
  assign done_right_o = ws_q;
  assign done_word_o  = word_q;
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              done_right_i,
  input  logic [WORD_W-1:0] done_word_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] left_hold_q;
  logic              have_left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (!done_right_i) begin
          left_hold_q <= done_word_i;
          have_left_q <= 1'b1;
        end else begin
          have_left_q <= 1'b0;
          if (have_left_q) begin
            left_o  <= left_hold_q;
            right_o <= done_word_i;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aud_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              sck_inv_i,
  input  logic              ws_inv_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [2:0]        pins_s;
  logic              sck_s, sck_d_q, ws_s, samp_edge;
  logic              half_done, half_right;
  logic [WORD_W-1:0] half_word;

  aud_rx_sync #(.W(3), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sd_i, ws_i, sck_i}),
    .sync_o  (pins_s)
  );

  assign sck_s = pins_s[0] ^ sck_inv_i;
  assign ws_s  = pins_s[1] ^ ws_inv_i;

  // reset high so the synchronizer settling out of reset is not taken as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b1;
    else         sck_d_q <= sck_s;
  end

  assign samp_edge = sck_s & ~sck_d_q;

  aud_rx_shift u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .samp_i       (samp_edge),
    .ws_i         (ws_s),
    .sd_i         (pins_s[2]),
    .fmt_i        (fmt_i),
    .wlen_i       (wlen_i),
    .done_o       (half_done),
    .done_right_o (half_right),
    .done_word_o  (half_word)
  );

  aud_rx_frame #(.WORD_W(WORD_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (half_done),
    .done_right_i (half_right),
    .done_word_i  (half_word),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o)
  );
endmodule

// File: rtl/aud_rx_checker.sv
module aud_rx_checker #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] left_i,
  input logic [WORD_W-1:0] right_i,
  input logic              samp_i,
  input logic              done_i
);
  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_after_half_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(done_i));

  p_after_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(samp_i));

  p_hold_left_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(left_i));

  p_hold_right_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(right_i));
endmodule

bind audio_serial_rx aud_rx_checker #(.WORD_W(24)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_o),
  .left_i  (left_o),
  .right_i (right_o),
  .samp_i  (samp_edge),
  .done_i  (half_done)
);

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0, wlen_i = 2'd0;
  logic        sck_inv_i = 1'b0, ws_inv_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  always #4 clk = ~clk;

  audio_serial_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
    .fmt_i(fmt_i), .wlen_i(wlen_i), .sck_inv_i(sck_inv_i), .ws_inv_i(ws_inv_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  int cyc = 0, n_chk = 0, n_fail = 0, n_valid = 0, last_rise = 0;
  logic [23:0] exp_l [2];
  logic [23:0] exp_r [2];
  logic [31:0] seed = 32'h1234_5678;
  string cur_tag = "";
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // strobe monitor: data and exact latency
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (n_valid < 2) begin
        chk(left_o == exp_l[n_valid], {cur_tag, " left"}, left_o, exp_l[n_valid]);
        chk(right_o == exp_r[n_valid], {cur_tag, " right"}, right_o, exp_r[n_valid]);
        chk(cyc - last_rise == 3, "R9 latency", 24'(cyc - last_rise), 24'd3);
      end else begin
        chk(1'b0, "R8 extra strobe", 24'(n_valid), 24'd1);
      end
      n_valid++;
    end
  end

  task automatic drive_bit(bit lws, bit b);
    ws_i  = lws ^ ws_inv_i;
    sd_i  = b;
    sck_i = sck_inv_i;
    repeat (3) @(negedge clk);
    sck_i = ~sck_inv_i;
    last_rise = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(bit lws, logic [23:0] w, int n, int first);
    for (int k = 0; k < 32; k++) begin
      bit b;
      b = (k >= first && k < first + n) ? w[23 - (k - first)] : 1'b1;
      drive_bit(lws, b);
    end
  endtask

  function automatic logic [23:0] next_word(int n);
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:8] & (24'hFF_FFFF << (24 - n));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 4; w++) begin
        for (int p = 0; p < 4; p++) begin
          int n, first;
          n = (w == 1) ? 20 : (w == 2) ? 16 : 24;
          first = (f == 1) ? 0 : (f == 2) ? 32 - n : 1;
          cur_tag = $sformatf("%s R5 R6%s%s fmt=%0d wlen=%0d pol=%0d",
                              (f == 2) ? "R4" : (f == 1) ? "R3" : "R2",
                              (p != 0) ? " R7" : "",
                              (f == 3 || w == 3) ? " R10" : "", f, w, p);
          rst_ni    = 1'b0;
          fmt_i     = 2'(f);
          wlen_i    = 2'(w);
          sck_inv_i = p[0];
          ws_inv_i  = p[1];
          sck_i     = p[0];
          ws_i      = p[1];
          repeat (3) @(negedge clk);
          chk(left_o == 0 && right_o == 0 && !valid_o, "R1 reset",
              left_o | right_o | 24'(valid_o), 24'd0);
          rst_ni  = 1'b1;
          n_valid = 0;
          for (int i = 0; i < 2; i++) begin
            exp_l[i] = next_word(n);
            exp_r[i] = next_word(n);
          end
          // partial lead-in: must not produce a strobe (R8)
          drive_bit(1'b0, 1'b1);
          drive_bit(1'b0, 1'b0);
          for (int i = 0; i < 10; i++) drive_bit(1'b1, 1'b1);
          for (int i = 0; i < 2; i++) begin
            send_half(1'b0, exp_l[i], n, first);
            send_half(1'b1, exp_r[i], n, first);
          end
          drive_bit(1'b0, 1'b1);
          drive_bit(1'b0, 1'b1);
          chk(n_valid == 2, "R8 strobe count", 24'(n_valid), 24'd2);
          chk(left_o == exp_l[1] && right_o == exp_r[1] && !valid_o, "R9 hold",
              left_o, exp_l[1]);
        end
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule